// File: doc/BRIEF.md
# Two-Stage Latched Code Register for a Multiplying DAC

This block is the digital front end of an 8-bit multiplying converter. A byte from the data bus passes through two cascaded holding registers before it reaches the converter core. The first is a capture stage, opened by a chip-select, a capture enable and a first write strobe. The second is a drive stage, opened by a second write strobe together with a transfer strobe. The drive stage supplies the code that steers the main current output. Its bitwise complement is also supplied for the second current output.

Because the two stages open independently, several units can each be pre-loaded with a new code. One shared transfer strobe then updates all of them at once. Tying controls to fixed levels gives the other modes: single-buffered use, or flow-through, where the output simply tracks the bus.

All controls act on level. A fast sampling clock models the level behaviour: the inputs pass through a two-flop synchronizer, and each stage reloads on every rising edge while its open condition holds. No valid/ready handshake applies. The bus is level-qualified by the strobes, and there is no back-pressure.

Top module: `dac_dbuf_frontend`

## Requirements
- R1: A synchronous active-high `rst` clears both stages. While reset is applied, and afterwards until a stage is opened, `code_true` reads 0 and `code_comp` reads 255.
- R2: The capture stage loads the synchronized bus while `cs_n`=0, `wr1_n`=0 and `lat_en`=1.
- R3: The capture stage holds its value while `cs_n`=1 or `wr1_n`=1. Bus changes during that time never reach the output.
- R4: The drive stage copies the capture stage only while `wr2_n`=0 and `xfer_n`=0. If either of them is 1, `code_true` holds.
- R5: Flow-through strapping makes `code_true` follow `bus_data`. This strapping is `cs_n`, `wr1_n`, `wr2_n` and `xfer_n` all 0, with `lat_en` 1.
- R6: `code_comp` always equals 255 minus `code_true`.
- R7: Bit order is kept. `bus_data[0]` is the least significant bit and `bus_data[7]` the most significant bit of `code_true`, read as unsigned. Code 0 is the minimum and 255 the full-scale maximum.
- R8: Under flow-through strapping, a bus change is applied after a clock edge. `code_true` still shows the old code after the 3rd following rising edge and the new code after the 4th.
- R9: While the drive stage is closed, a new byte can be captured without disturbing `code_true`. It appears only when the transfer opens the drive stage.
- R10: Holding `lat_en` at 0 freezes the capture stage. No activity on the bus or on the strobes then changes the output, even with every other control in its flow-through state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_data | input | 8 | Data bus, bit 0 is the LSB |
| cs_n | input | 1 | Chip select, active low |
| lat_en | input | 1 | Capture enable, active high |
| wr1_n | input | 1 | First write strobe, active low |
| wr2_n | input | 1 | Second write strobe, active low |
| xfer_n | input | 1 | Transfer strobe, active low |
| code_true | output | 8 | Drive stage contents |
| code_comp | output | 8 | Bitwise complement of the drive stage |

## Verification
The bench drives flow-through bytes 0xA5, 0x3C, 0x01 and 0x80. These show that the output follows the bus, that bit order is kept, and the exact latency, observed one edge before and at the edge of change. A double-buffered sequence captures one byte, changes the bus, then transfers. This tells the capture stage's hold apart from its load, and the transfer's effect apart from that of either strobe alone. Separate patterns close the capture stage with chip-select high or with the capture enable low, while the bus keeps moving. They show that each qualifier blocks the load on its own. Every comparison also checks the complement output.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;
  localparam int CTL_W = 5;

  typedef struct packed {
    logic cs_n;
    logic lat_en;
    logic wr1_n;
    logic wr2_n;
    logic xfer_n;
  } ctl_t;

  // Idle levels: every stage closed.
  localparam ctl_t CTL_IDLE = '{cs_n: 1'b1, lat_en: 1'b0, wr1_n: 1'b1,
                                wr2_n: 1'b1, xfer_n: 1'b1};
endpackage

// File: rtl/dac_fe_sync.sv
module dac_fe_sync #(
  parameter int              W      = 8,
  parameter int              STAGES = 2,
  parameter logic [W-1:0]    RST_V  = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= {STAGES{RST_V[b]}};
      else     sh <= {sh[STAGES-2:0], din[b]};
    end
    assign dout[b] = sh[STAGES-1];
  end
endmodule

// File: rtl/dac_fe_stage.sv
module dac_fe_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end

  // R3 / R4: a closed stage keeps its contents
  a_r3_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(en) && !$past(rst) |-> $stable(q));
  // R2: an open stage takes the value presented one edge earlier
  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    $past(en) && !$past(rst) |-> q == $past(d));
endmodule

// File: rtl/dac_dbuf_frontend.sv
module dac_dbuf_frontend
  import dac_fe_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] bus_data,
  input  logic          cs_n,
  input  logic          lat_en,
  input  logic          wr1_n,
  input  logic          wr2_n,
  input  logic          xfer_n,
  output logic [DW-1:0] code_true,
  output logic [DW-1:0] code_comp
);
  localparam int SW = DW + CTL_W;
  localparam logic [SW-1:0] SYNC_RST = {{DW{1'b0}}, CTL_IDLE};

  ctl_t          ctl_raw, ctl_s;
  logic [DW-1:0] data_s;
  logic [DW-1:0] cap_q;
  logic          cap_open, drv_open;

  assign ctl_raw = '{cs_n: cs_n, lat_en: lat_en, wr1_n: wr1_n,
                     wr2_n: wr2_n, xfer_n: xfer_n};

  dac_fe_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_V(SYNC_RST)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({bus_data, ctl_raw}),
    .dout ({data_s, ctl_s})
  );

  assign cap_open = !ctl_s.cs_n && !ctl_s.wr1_n && ctl_s.lat_en;
  assign drv_open = !ctl_s.wr2_n && !ctl_s.xfer_n;

  dac_fe_stage #(.W(DW)) u_capture (
    .clk (clk), .rst (rst), .en (cap_open), .d (data_s), .q (cap_q)
  );

  dac_fe_stage #(.W(DW)) u_drive (
    .clk (clk), .rst (rst), .en (drv_open), .d (cap_q), .q (code_true)
  );

  assign code_comp = ~code_true;

  // R1: cleared contents right after reset
  a_r1_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> code_true == '0);

  if (SYNC_STAGES == 2) begin : g_flow_chk
    logic flow;
    assign flow = !cs_n && !wr1_n && !wr2_n && !xfer_n && lat_en;
    // R5 / R8: with flow-through strapping held, the output is the bus four edges back
    a_r5_r8_flow: assert property (@(posedge clk) disable iff (rst)
      $past(flow,1) && $past(flow,2) && $past(flow,3) && $past(flow,4) &&
      !$past(rst,1) && !$past(rst,2) && !$past(rst,3) && !$past(rst,4)
      |-> code_true == $past(bus_data,4));
  end
endmodule

// File: tb/test_dac_dbuf_frontend.sv
module test_dac_dbuf_frontend;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_data = 8'h00;
  logic       cs_n = 1'b1, lat_en = 1'b0, wr1_n = 1'b1, wr2_n = 1'b1, xfer_n = 1'b1;
  logic [7:0] code_true, code_comp;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  typedef struct { logic [7:0] exp; int due; string tag; } item_t;
  item_t sb[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dac_dbuf_frontend i_dac_dbuf_frontend (
    .clk(clk), .rst(rst), .bus_data(bus_data), .cs_n(cs_n), .lat_en(lat_en),
    .wr1_n(wr1_n), .wr2_n(wr2_n), .xfer_n(xfer_n),
    .code_true(code_true), .code_comp(code_comp)
  );

  task automatic check(string tag, logic [7:0] exp);
    checks++;
    if (code_true !== exp || code_comp !== (8'hFF - exp)) begin
      failures++;
      $display("FAIL %s: true=%02h comp=%02h expected true=%02h comp=%02h (R6)",
               tag, code_true, code_comp, exp, 8'hFF - exp);
    end
  endtask

  // monitor: pops expected items once due and compares
  always @(negedge clk) begin
    if (sb.size() > 0 && cyc >= sb[0].due) begin
      item_t it;
      it = sb.pop_front();
      check(it.tag, it.exp);
    end
  end

  // driver: applies controls and data, queues the expected code
  task automatic drive(logic c, logic le, logic w1, logic w2, logic x,
                       logic [7:0] d, logic [7:0] exp, int wait_n, string tag);
    @(negedge clk);
    cs_n = c; lat_en = le; wr1_n = w1; wr2_n = w2; xfer_n = x; bus_data = d;
    sb.push_back('{exp: exp, due: cyc + wait_n, tag: tag});
    wait (sb.size() == 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 during reset", 8'h00);
    @(negedge clk); rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 after reset", 8'h00);

    // flow-through
    drive(0, 1, 0, 0, 0, 8'hA5, 8'hA5, 6, "R5 flow A5");
    @(negedge clk);
    bus_data = 8'h3C;
    sb.push_back('{exp: 8'hA5, due: cyc + 3, tag: "R8 old code at edge 3"});
    sb.push_back('{exp: 8'h3C, due: cyc + 4, tag: "R8 new code at edge 4"});
    wait (sb.size() == 0);
    drive(0, 1, 0, 0, 0, 8'h01, 8'h01, 6, "R7 LSB code 01");
    drive(0, 1, 0, 0, 0, 8'h80, 8'h80, 6, "R7 MSB code 80");

    // double-buffered: drive stage closed, capture 5A
    drive(0, 1, 0, 1, 1, 8'h5A, 8'h80, 6, "R9 capture without output change");
    drive(0, 1, 1, 1, 1, 8'hFF, 8'h80, 6, "R3 wr1 high hold");
    drive(0, 1, 1, 1, 0, 8'hFF, 8'h80, 6, "R4 xfer alone holds");
    drive(0, 1, 1, 0, 1, 8'hFF, 8'h80, 6, "R4 wr2 alone holds");
    drive(0, 1, 1, 0, 0, 8'hFF, 8'h5A, 6, "R2 R9 transfer shows captured 5A");

    // chip select high blocks capture
    drive(1, 1, 0, 0, 0, 8'h11, 8'h5A, 6, "R3 cs high hold");
    // capture enable low freezes even with flow-through strobes
    drive(0, 0, 0, 0, 0, 8'h77, 8'h5A, 6, "R10 freeze");
    drive(0, 0, 0, 0, 0, 8'h00, 8'h5A, 6, "R10 freeze bus 00");
    drive(0, 1, 0, 0, 0, 8'hFF, 8'hFF, 6, "R7 full scale FF");

    // reset mid-run
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 mid-run reset", 8'h00);
    rst = 1'b0; cs_n = 1'b1; lat_en = 1'b0;
    repeat (6) @(negedge clk);
    check("R1 stays clear while closed", 8'h00);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog: run hung, actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule